// File: doc/BRIEF.md
# Programmable FIFO Flag Router

This block watches the occupancy counts of two independent FIFOs, one carrying traffic from side A to side B and one carrying it back. For each FIFO it produces four registered status flags: empty, almost empty, almost full and full. That gives eight internal flags. Four external flag pins can each be pointed at any one of the eight by a 4-bit select code. A 16-bit status word exposes the flags in a fixed layout, together with a transfer-direction bit.

The two almost-flag thresholds of each FIFO come from programmable offset registers. A small flat register port writes and reads the four offset registers and the pin-assignment register. A configuration-clear input puts all five registers back to their defaults in one cycle. The FIFO storage, the pointer logic and the host bus decoding sit outside this block.

Top module: `flag_router`

## Requirements
- R1: After reset, the four offset registers read 0 and the pin-assignment register reads 16'h6420. With both counts at 0, the pins are {D,C,B,A} = 4'b1010.
- R2: Empty is set when a count is 0, and full is set when a count equals DEPTH. Each flag is registered and changes on the first clock edge after the count changes.
- R3: Almost-empty is set when the count is less than or equal to the almost-empty offset of that FIFO.
- R4: Almost-full is set when the count is greater than or equal to DEPTH minus the almost-full offset of that FIFO.
- R5: Pin n (A=0, B=1, C=2, D=3) shows the flag chosen by bits [4n+3:4n] of the assignment register. The codes are:
  - 0 = A-to-B full
  - 1 = A-to-B almost full
  - 2 = A-to-B empty
  - 3 = A-to-B almost empty
  - 4 = B-to-A full
  - 5 = B-to-A almost full
  - 6 = B-to-A empty
  - 7 = B-to-A almost empty
- R6: Select codes 8 to 15 drive their pin low.
- R7: Status word layout:
  - bit 3 = direction input
  - bits 4..7 = A-to-B empty, A-to-B almost empty, B-to-A full, B-to-A almost full
  - bits 12..15 = A-to-B full, A-to-B almost full, B-to-A empty, B-to-A almost empty
  - all other bits read 0
- R8: The register port uses addresses 0..4:
  - 0 = A-to-B almost-empty offset
  - 1 = A-to-B almost-full offset
  - 2 = B-to-A almost-empty offset
  - 3 = B-to-A almost-full offset
  - 4 = pin assignment
  - Offset bits at and above OFS_W read 0.
  - Addresses 5..7 read 0, and writes to them change nothing.
- R9: Configuration clear restores every register to its reset value. It wins over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ab_count | input | CNT_W | Occupancy of the A-to-B FIFO |
| ba_count | input | CNT_W | Occupancy of the B-to-A FIFO |
| dir_in | input | 1 | Transfer direction bit, copied into the status word |
| cfg_clear | input | 1 | Restore all registers to defaults |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from the address |
| flag_pins | output | 4 | External flags, bit 0 = pin A |
| status_word | output | 16 | Flag status word |

## Verification
The assertions assume that no occupancy count ever exceeds DEPTH, since a real FIFO cannot hold more than its depth. The empty-implies-almost-empty and full-implies-almost-full checks also depend on every offset being smaller than DEPTH, which the offset register width guarantees. The stimulus keeps both counts within 0..DEPTH at all times. It also writes offsets no larger than DEPTH-1, apart from one masking check in which the upper bits are dropped by the register.

// File: rtl/flag_router_pkg.sv
package flag_router_pkg;
  localparam int REG_W     = 16;
  localparam int SEL_W     = 4;
  localparam int NUM_PINS  = 4;
  localparam int NUM_FLAGS = 8;
  localparam int ADDR_W    = 3;
  localparam int FLAGS_PER = 4;

  // bit positions inside one FIFO's 4-bit flag group (low bits of the select code)
  localparam int FB_FULL  = 0;
  localparam int FB_AFULL = 1;
  localparam int FB_EMPTY = 2;
  localparam int FB_AEMPT = 3;

  localparam logic [REG_W-1:0] ASSIGN_DEFAULT = 16'h6420;

  localparam logic [ADDR_W-1:0] ADDR_ASSIGN = 3'd4;
endpackage

// File: rtl/flag_cfg_regs.sv
module flag_cfg_regs
  import flag_router_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_clear,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [OFS_W-1:0]  ofs_ab_ae,
  output logic [OFS_W-1:0]  ofs_ab_af,
  output logic [OFS_W-1:0]  ofs_ba_ae,
  output logic [OFS_W-1:0]  ofs_ba_af,
  output logic [REG_W-1:0]  pin_sel
);
  localparam int NUM_OFS = 4;

  logic [OFS_W-1:0] ofs_q [NUM_OFS];
  logic [OFS_W-1:0] ofs_d [NUM_OFS];
  logic [REG_W-1:0] asg_q, asg_d;
  logic             load_en;

  // next-state
  always_comb begin
    for (int i = 0; i < NUM_OFS; i++) ofs_d[i] = ofs_q[i];
    asg_d = asg_q;
    if (cfg_clear) begin
      for (int i = 0; i < NUM_OFS; i++) ofs_d[i] = '0;
      asg_d = ASSIGN_DEFAULT;
    end else if (wr_en) begin
      if (!addr[ADDR_W-1])        ofs_d[addr[1:0]] = wdata[OFS_W-1:0];
      else if (addr == ADDR_ASSIGN) asg_d = wdata;
    end
  end

  assign load_en = cfg_clear | wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_OFS; i++) ofs_q[i] <= '0;
      asg_q <= ASSIGN_DEFAULT;
    end else if (load_en) begin
      for (int i = 0; i < NUM_OFS; i++) ofs_q[i] <= ofs_d[i];
      asg_q <= asg_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (!addr[ADDR_W-1])          rdata = {{(REG_W-OFS_W){1'b0}}, ofs_q[addr[1:0]]};
    else if (addr == ADDR_ASSIGN) rdata = asg_q;
  end

  assign ofs_ab_ae = ofs_q[0];
  assign ofs_ab_af = ofs_q[1];
  assign ofs_ba_ae = ofs_q[2];
  assign ofs_ba_af = ofs_q[3];
  assign pin_sel   = asg_q;

  assert_clear_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |=> (asg_q == ASSIGN_DEFAULT && ofs_q[0] == '0 && ofs_q[1] == '0
                   && ofs_q[2] == '0 && ofs_q[3] == '0));

  assert_assign_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cfg_clear && addr == ADDR_ASSIGN) |=> (asg_q == $past(wdata)));

  assert_unused_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cfg_clear && addr > ADDR_ASSIGN) |=> $stable(asg_q));
endmodule

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen
  import flag_router_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int OFS_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     count,
  input  logic [OFS_W-1:0]     ae_ofs,
  input  logic [OFS_W-1:0]     af_ofs,
  output logic [FLAGS_PER-1:0] flags_q
);
  localparam int CMP_W = CNT_W + 1;
  localparam logic [CMP_W-1:0] DEPTH_C = CMP_W'(DEPTH);

  logic [FLAGS_PER-1:0] flags_d;
  logic [CMP_W-1:0]     cnt_ext, af_sum;

  assign cnt_ext = {1'b0, count};
  assign af_sum  = cnt_ext + CMP_W'(af_ofs);

  // next-state
  always_comb begin
    flags_d           = '0;
    flags_d[FB_EMPTY] = (count == '0);
    flags_d[FB_FULL]  = (cnt_ext == DEPTH_C);
    flags_d[FB_AEMPT] = (cnt_ext <= CMP_W'(ae_ofs));
    flags_d[FB_AFULL] = (af_sum >= DEPTH_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ext <= DEPTH_C);

  assert_empty_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |=> flags_q[FB_EMPTY]);

  assert_empty_in_ae_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[FB_EMPTY] |-> flags_q[FB_AEMPT]);

  assert_full_in_af_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[FB_FULL] |-> flags_q[FB_AFULL]);
endmodule

// File: rtl/flag_pin_mux.sv
module flag_pin_mux
  import flag_router_pkg::*;
(
  input  logic [NUM_FLAGS-1:0]      flags,
  input  logic [NUM_PINS*SEL_W-1:0] pin_sel,
  output logic [NUM_PINS-1:0]       pins
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SEL_W-1:0] sel;
    assign sel     = pin_sel[p*SEL_W +: SEL_W];
    assign pins[p] = sel[SEL_W-1] ? 1'b0 : flags[sel[SEL_W-2:0]];
  end
endmodule

// File: rtl/flag_router.sv
module flag_router
  import flag_router_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int OFS_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    ab_count,
  input  logic [CNT_W-1:0]    ba_count,
  input  logic                dir_in,
  input  logic                cfg_clear,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic [NUM_PINS-1:0] flag_pins,
  output logic [REG_W-1:0]    status_word
);
  localparam int NUM_FIFOS = 2;

  logic [1:0]           rst_sync;
  logic                 rst_int_n;
  logic [OFS_W-1:0]     ofs_ae [NUM_FIFOS];
  logic [OFS_W-1:0]     ofs_af [NUM_FIFOS];
  logic [CNT_W-1:0]     counts [NUM_FIFOS];
  logic [REG_W-1:0]     pin_sel;
  logic [NUM_FLAGS-1:0] flags;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  flag_cfg_regs #(.OFS_W(OFS_W)) regs_i (
    .clk(clk), .rst_n(rst_int_n), .cfg_clear(cfg_clear), .wr_en(reg_wr),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .ofs_ab_ae(ofs_ae[0]), .ofs_ab_af(ofs_af[0]),
    .ofs_ba_ae(ofs_ae[1]), .ofs_ba_af(ofs_af[1]),
    .pin_sel(pin_sel)
  );

  assign counts[0] = ab_count;
  assign counts[1] = ba_count;

  for (genvar f = 0; f < NUM_FIFOS; f++) begin : g_fifo
    fifo_flag_gen #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OFS_W(OFS_W)) gen_i (
      .clk(clk), .rst_n(rst_int_n), .count(counts[f]),
      .ae_ofs(ofs_ae[f]), .af_ofs(ofs_af[f]),
      .flags_q(flags[f*FLAGS_PER +: FLAGS_PER])
    );
  end

  flag_pin_mux mux_i (.flags(flags), .pin_sel(pin_sel), .pins(flag_pins));

  localparam int BA = FLAGS_PER;
  always_comb begin
    status_word     = '0;
    status_word[3]  = dir_in;
    status_word[4]  = flags[FB_EMPTY];
    status_word[5]  = flags[FB_AEMPT];
    status_word[6]  = flags[BA + FB_FULL];
    status_word[7]  = flags[BA + FB_AFULL];
    status_word[12] = flags[FB_FULL];
    status_word[13] = flags[FB_AFULL];
    status_word[14] = flags[BA + FB_EMPTY];
    status_word[15] = flags[BA + FB_AEMPT];
  end

  assert_high_code_pin_a_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    pin_sel[SEL_W-1] |-> !flag_pins[0]);
endmodule

// File: tb/flag_router_tb_top.sv
module flag_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;
  localparam int CNT_W = 11;
  localparam int NV    = 6;

  typedef struct packed {
    logic [CNT_W-1:0] ab;
    logic [CNT_W-1:0] ba;
    logic [9:0]  o_ab_ae;
    logic [9:0]  o_ab_af;
    logic [9:0]  o_ba_ae;
    logic [9:0]  o_ba_af;
    logic [15:0] asg;
    logic        dir;
    logic [3:0]  pins;
    logic [15:0] stat;
  } vec_t;

  // ab, ba, ofs x4, assignment, dir, expected pins, expected status
  localparam vec_t VECS [NV] = '{
    '{11'd0,    11'd1024, 10'd0,    10'd0,  10'd0, 10'd0,  16'h6420, 1'b0, 4'h6, 16'h00F0},
    '{11'd10,   11'd1000, 10'd10,   10'd24, 10'd9, 10'd23, 16'h7531, 1'b1, 4'h2, 16'h0028},
    '{11'd11,   11'd1001, 10'd10,   10'd24, 10'd9, 10'd23, 16'h7531, 1'b0, 4'h4, 16'h0080},
    '{11'd1014, 11'd0,    10'd1023, 10'd10, 10'd0, 10'd0,  16'h3210, 1'b1, 4'hA, 16'hE028},
    '{11'd0,    11'd1024, 10'd0,    10'd0,  10'd0, 10'd0,  16'h8C4F, 1'b0, 4'h2, 16'h00F0},
    '{11'd1024, 11'd0,    10'd0,    10'd0,  10'd0, 10'd0,  16'h1357, 1'b0, 4'h9, 16'hF000}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [CNT_W-1:0] ab_count, ba_count;
  logic dir_in, cfg_clear, reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, status_word;
  logic [3:0]  flag_pins;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_router #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .ab_count(ab_count), .ba_count(ba_count),
    .dir_in(dir_in), .cfg_clear(cfg_clear), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flag_pins(flag_pins), .status_word(status_word)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; ab_count = '0; ba_count = '0; dir_in = 1'b0;
    cfg_clear = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(3'd4, v); check("R1 assign reset", v, 16'h6420);
    rd(3'd0, v); check("R1 offset reset", v, 16'h0000);
    rd(3'd3, v); check("R1 offset reset", v, 16'h0000);
    check("R1 pins reset", {12'h0, flag_pins}, 16'h000A);

    // table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, {6'h0, VECS[i].o_ab_ae});
      wr(3'd1, {6'h0, VECS[i].o_ab_af});
      wr(3'd2, {6'h0, VECS[i].o_ba_ae});
      wr(3'd3, {6'h0, VECS[i].o_ba_af});
      wr(3'd4, VECS[i].asg);
      @(negedge clk);
      ab_count = VECS[i].ab; ba_count = VECS[i].ba; dir_in = VECS[i].dir;
      @(negedge clk);
      @(negedge clk);
      check("R5 R6 pins (vector)", {12'h0, flag_pins}, {12'h0, VECS[i].pins});
      check("R3 R4 R7 status (vector)", status_word, VECS[i].stat);
    end

    // R8: offset masking, unused addresses
    wr(3'd0, 16'hFFFF);
    rd(3'd0, v); check("R8 offset upper bits", v, 16'h03FF);
    wr(3'd5, 16'hBEEF);
    rd(3'd5, v); check("R8 unused addr reads 0", v, 16'h0000);
    rd(3'd4, v); check("R8 unused write no effect", v, 16'h1357);
    check("R8 pins unchanged", {12'h0, flag_pins}, 16'h0009);

    // R9: clear beats a simultaneous write
    wr(3'd1, 16'h0033);
    @(negedge clk);
    cfg_clear = 1'b1; reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 16'h1234;
    @(negedge clk);
    cfg_clear = 1'b0; reg_wr = 1'b0;
    rd(3'd4, v); check("R9 assign default", v, 16'h6420);
    rd(3'd1, v); check("R9 offset cleared", v, 16'h0000);
    rd(3'd0, v); check("R9 offset cleared", v, 16'h0000);

    // R2: one-clock latency of empty and full
    ab_count = '0; ba_count = '0;
    repeat (2) @(negedge clk);
    ab_count = 11'd5;
    #1 check("R2 empty before edge", {15'h0, status_word[4]}, 16'h0001);
    @(negedge clk);
    check("R2 empty after edge", {15'h0, status_word[4]}, 16'h0000);
    check("R2 pin B follows empty", {15'h0, flag_pins[1]}, 16'h0000);
    ab_count = 11'd1024;
    #1 check("R2 full before edge", {15'h0, status_word[12]}, 16'h0000);
    @(negedge clk);
    check("R2 full after edge", {15'h0, status_word[12]}, 16'h0001);
    check("R2 pin A follows full", {15'h0, flag_pins[0]}, 16'h0001);
    ab_count = 11'd1023;
    @(negedge clk);
    check("R2 full drops below depth", {15'h0, status_word[12]}, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule